// File: doc/BRIEF.md
# USB Device Endpoint Control

This block holds the configuration and arming state of every endpoint in a full-speed USB device controller. It decides how each endpoint answers a token. A CPU-side register port sets up each endpoint: its address number, its direction, isochronous mode, a buffer segment and a data-toggle bit. The CPU starts a transfer by writing a payload length, and that one write also arms the endpoint. A self-clearing write-one control bit withdraws a pending arming before the host asks for it.

A serial interface engine sends decoded tokens to the block: IN, OUT or SETUP with a 4-bit endpoint address. One cycle later the block answers with the matching endpoint index, its buffer start address, a byte count, the DATA PID to use, whether a data phase happens, and the handshake to give. When the engine finishes the data phase it reports success and the received byte count. The block then updates the endpoint's toggle, its arming and its length register. It also reports the final handshake for the receive direction, or flags an over-length packet.

Top module: `usb_ep_ctrl`

## Requirements
- R1: After reset every endpoint register reads zero, so every endpoint is disabled and unarmed, and neither `rsp_valid` nor `fin_valid` is asserted.
- R2: Register 0 of an endpoint holds a 6-bit segment in write/read bits [8:3]. A response's `rsp_addr` equals SRAM_BASE (default 0x100) plus the segment times 8.
- R3: The endpoint mode (config bits [6:5]) is 00 for disabled, 01 for OUT and 10 for IN. Mode 11 behaves as disabled. A token that matches no enabled endpoint gives `rsp_hit`=0, no data phase and handshake NONE.
- R4: A token matches an enabled endpoint whose number (config bits [3:0]) equals `tok_ep` and whose direction fits the token: IN tokens go to IN endpoints, and OUT or SETUP tokens go to OUT endpoints. When several endpoints match, the lowest index wins and is returned in `rsp_idx`.
- R5: For an IN or OUT token, an unarmed, non-stalled, non-isochronous endpoint answers NAK with no data phase. An armed endpoint gets a data phase, `rsp_len` gives its length register, and the handshake is NONE for IN (data is sent) and ACK for OUT. Handshake codes: 0 NONE, 1 ACK, 2 NAK, 3 STALL.
- R6: While the stall bit (control register bit 1) is set, IN and OUT tokens are answered with STALL and no data phase, whether or not the endpoint is armed.
- R7: With the isochronous bit (config bit 4) set, the endpoint never gives ACK or NAK. It answers NONE both at token time and at completion.
- R8: `rsp_data1` carries the toggle (config bit 7) for IN and OUT tokens. A successful IN completion inverts the toggle and disarms the endpoint. A failed completion changes neither.
- R9: A successful OUT completion with a count no greater than the armed length writes the count into the length register, disarms the endpoint and reports ACK. A larger count sets `fin_err`, reports no ACK and leaves the endpoint armed.
- R10: Writing 1 to control bit 0 disarms the endpoint and the bit always reads 0. While a granted transaction on that endpoint awaits completion, the write has no effect on arming.
- R11: A SETUP token that matches is answered ACK with a data phase and `rsp_data1`=0, even when stalled or unarmed. Its successful completion reports ACK, stores the count in the length register and sets the toggle to 1.
- R12: A response is valid exactly one cycle after each token. A completion result is valid one cycle after a completion report that follows a granted data phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | IDX_W+2 | Endpoint index (upper bits) and register select (lower 2 bits) |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data of the addressed register (combinational) |
| tok_valid | input | 1 | Token event strobe |
| tok_pid | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP |
| tok_ep | input | 4 | Token endpoint address |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | An endpoint matched |
| rsp_idx | output | IDX_W | Index of the matched endpoint |
| rsp_addr | output | ADDR_W | Buffer start address |
| rsp_len | output | 9 | Byte count to send or maximum to accept |
| rsp_data1 | output | 1 | 1 selects DATA1, 0 selects DATA0 |
| rsp_data | output | 1 | A data phase follows |
| rsp_hs | output | 2 | Handshake at token time |
| done_valid | input | 1 | Data phase finished |
| done_ok | input | 1 | Data phase succeeded |
| done_cnt | input | 9 | Bytes received |
| fin_valid | output | 1 | Completion result strobe |
| fin_hs | output | 2 | Handshake to send after received data |
| fin_err | output | 1 | Received packet exceeded the armed length |

## Verification
Each token's response is registered once, so it appears on the cycle after `tok_valid` is sampled. Completion results and the register updates they cause also land one edge after `done_valid`. The bench drives inputs on the falling edge and samples the response outputs 1 ns after the next rising edge. Register reads are combinational, so they are checked 1 ns after the address is set, with no clock in between. A write therefore becomes visible from the first read that follows the edge that captured it.

// File: rtl/usbep_pkg.sv
package usbep_pkg;

    // Field widths of the per-endpoint registers
    localparam int LEN_W  = 9;
    localparam int SEG_W  = 6;
    localparam int NUM_W  = 4;
    localparam int DATA_W = 16;

    // Register selectors inside one endpoint's window
    localparam logic [1:0] SEL_SEG = 2'd0;
    localparam logic [1:0] SEL_LEN = 2'd1;
    localparam logic [1:0] SEL_CFG = 2'd2;
    localparam logic [1:0] SEL_CTL = 2'd3;

    // Endpoint mode encodings
    localparam logic [1:0] MODE_OFF = 2'b00;
    localparam logic [1:0] MODE_OUT = 2'b01;
    localparam logic [1:0] MODE_IN  = 2'b10;

    typedef enum logic [1:0] {
        TK_OUT   = 2'd0,
        TK_IN    = 2'd1,
        TK_SETUP = 2'd2,
        TK_RSVD  = 2'd3
    } tok_e;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_e;

    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic [LEN_W-1:0] len;
        logic [NUM_W-1:0] num;
        logic             iso;
        logic [1:0]       mode;
        logic             dsq;
        logic             stall;
        logic             armed;
    } ep_st_t;

endpackage

// File: rtl/usbep_slot.sv
// Holds the state of one endpoint: segment, length, config, stall and arming.
// Assumes at most one completion strobe per cycle. A CPU write in the same
// cycle as a completion overrides the fields that the write touches.
module usbep_slot
    import usbep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              cmp_in_ok,
    input  logic              cmp_out_ok,
    input  logic              cmp_setup,
    input  logic [LEN_W-1:0]  cmp_cnt,
    output ep_st_t            st
);

    localparam int SEG_LSB = 3;

    // Register update from completions, then from CPU writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else begin
            if (cmp_in_ok) begin
                st.dsq   <= ~st.dsq;
                st.armed <= 1'b0;
            end
            if (cmp_out_ok) begin
                st.len   <= cmp_cnt;
                st.armed <= 1'b0;
            end
            if (cmp_setup) begin
                st.len <= cmp_cnt;
                st.dsq <= 1'b1;
            end
            if (wr_en) begin
                case (wr_sel)
                    SEL_SEG: st.seg <= wr_data[SEG_LSB +: SEG_W];
                    SEL_LEN: begin
                        st.len   <= wr_data[LEN_W-1:0];
                        st.armed <= 1'b1;
                    end
                    SEL_CFG: begin
                        st.num  <= wr_data[NUM_W-1:0];
                        st.iso  <= wr_data[4];
                        st.mode <= wr_data[6:5];
                        st.dsq  <= wr_data[7];
                    end
                    default: begin
                        st.stall <= wr_data[1];
                        if (wr_data[0] && !busy) begin
                            st.armed <= 1'b0;
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/usbep_match.sv
// Finds the lowest-index enabled endpoint whose number and direction fit a
// token. Purely combinational; mode 11 counts as disabled.
module usbep_match
    import usbep_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int IDX_W  = 2
) (
    input  ep_st_t            eps [NUM_EP],
    input  logic [1:0]        tok_pid,
    input  logic [NUM_W-1:0]  tok_ep,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);

    logic [NUM_EP-1:0] fit;

    genvar g;
    generate
        for (g = 0; g < NUM_EP; g++) begin : g_fit
            // Per-endpoint match: number equal and direction suits the token
            always_comb begin
                fit[g] = 1'b0;
                if (eps[g].num == tok_ep) begin
                    case (tok_pid)
                        TK_IN:    fit[g] = (eps[g].mode == MODE_IN);
                        TK_OUT,
                        TK_SETUP: fit[g] = (eps[g].mode == MODE_OUT);
                        default:  fit[g] = 1'b0;
                    endcase
                end
            end
        end
    endgenerate

    // Priority pick: scan downward so the lowest index ends up selected
    always_comb begin
        hit = |fit;
        idx = '0;
        for (int i = NUM_EP - 1; i >= 0; i--) begin
            if (fit[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/usbep_resp.sv
// Decides the token-time answer for the matched endpoint. It tracks the one
// transaction that is waiting for its data phase to end, and turns the
// completion report into endpoint updates and a final handshake. Assumes the
// engine reports at most one completion per granted token.
module usbep_resp
    import usbep_pkg::*;
#(
    parameter int          IDX_W     = 2,
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] SRAM_BASE = 12'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [1:0]        tok_pid,
    input  logic              m_hit,
    input  logic [IDX_W-1:0]  m_idx,
    input  ep_st_t            m_st,
    input  logic              done_valid,
    input  logic              done_ok,
    input  logic [LEN_W-1:0]  done_cnt,
    input  ep_st_t            p_st,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [LEN_W-1:0]  rsp_len,
    output logic              rsp_data1,
    output logic              rsp_data,
    output logic [1:0]        rsp_hs,
    output logic              fin_valid,
    output logic [1:0]        fin_hs,
    output logic              fin_err,
    output logic              pend,
    output logic [IDX_W-1:0]  pend_idx,
    output logic              cmp_in_ok,
    output logic              cmp_out_ok,
    output logic              cmp_setup,
    output logic [LEN_W-1:0]  cmp_cnt
);

    hs_e               nxt_hs;
    logic              nxt_data;
    logic              is_setup;
    logic [1:0]        pend_pid;
    logic              go;
    logic              fits;
    logic [ADDR_W-1:0] base_addr;

    assign is_setup  = (tok_pid == TK_SETUP);
    assign base_addr = ADDR_W'(SRAM_BASE);

    // Token-time decision: miss, SETUP, stall, unarmed, armed
    always_comb begin
        nxt_hs   = HS_NONE;
        nxt_data = 1'b0;
        if (!m_hit) begin
            nxt_hs = HS_NONE;
        end else if (is_setup) begin
            nxt_hs   = HS_ACK;
            nxt_data = 1'b1;
        end else if (m_st.stall) begin
            nxt_hs = HS_STALL;
        end else if (!m_st.armed) begin
            nxt_hs = m_st.iso ? HS_NONE : HS_NAK;
        end else begin
            nxt_data = 1'b1;
            nxt_hs   = (tok_pid == TK_OUT && !m_st.iso) ? HS_ACK : HS_NONE;
        end
    end

    // Register the response one cycle after the token
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_idx   <= '0;
            rsp_addr  <= '0;
            rsp_len   <= '0;
            rsp_data1 <= 1'b0;
            rsp_data  <= 1'b0;
            rsp_hs    <= HS_NONE;
        end else begin
            rsp_valid <= tok_valid;
            if (tok_valid) begin
                rsp_hit   <= m_hit;
                rsp_idx   <= m_idx;
                rsp_addr  <= base_addr + {{(ADDR_W-SEG_W-3){1'b0}}, m_st.seg, 3'b000};
                rsp_len   <= m_st.len;
                rsp_data1 <= is_setup ? 1'b0 : m_st.dsq;
                rsp_data  <= nxt_data;
                rsp_hs    <= nxt_hs;
            end
        end
    end

    // Track the granted transaction until its completion report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            pend_idx <= '0;
            pend_pid <= TK_OUT;
        end else if (tok_valid) begin
            pend     <= nxt_data;
            pend_idx <= m_idx;
            pend_pid <= tok_pid;
        end else if (done_valid) begin
            pend <= 1'b0;
        end
    end

    assign go         = done_valid && pend;
    assign fits       = (done_cnt <= p_st.len);
    assign cmp_in_ok  = go && done_ok && (pend_pid == TK_IN);
    assign cmp_out_ok = go && done_ok && (pend_pid == TK_OUT) && fits;
    assign cmp_setup  = go && done_ok && (pend_pid == TK_SETUP);
    assign cmp_cnt    = done_cnt;

    // Register the completion result one cycle after the report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_valid <= 1'b0;
            fin_hs    <= HS_NONE;
            fin_err   <= 1'b0;
        end else begin
            fin_valid <= go;
            fin_err   <= go && done_ok && (pend_pid == TK_OUT) && !fits;
            fin_hs    <= ((cmp_out_ok && !p_st.iso) || cmp_setup) ? HS_ACK : HS_NONE;
        end
    end

endmodule

// File: rtl/usb_ep_ctrl.sv
// Top of the endpoint control block: one register slot per endpoint, a token
// matcher, and the response/completion unit. CPU reads are combinational.
// Assumes tokens and completions arrive no more than one per cycle.
module usb_ep_ctrl
    import usbep_pkg::*;
#(
    parameter int          NUM_EP    = 4,
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] SRAM_BASE = 12'h100,
    localparam int         IDX_W     = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [IDX_W+1:0]  cpu_addr,
    input  logic [15:0]       cpu_wdata,
    output logic [15:0]       cpu_rdata,
    input  logic              tok_valid,
    input  logic [1:0]        tok_pid,
    input  logic [3:0]        tok_ep,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [8:0]        rsp_len,
    output logic              rsp_data1,
    output logic              rsp_data,
    output logic [1:0]        rsp_hs,
    input  logic              done_valid,
    input  logic              done_ok,
    input  logic [8:0]        done_cnt,
    output logic              fin_valid,
    output logic [1:0]        fin_hs,
    output logic              fin_err
);

    ep_st_t            eps [NUM_EP];
    logic [IDX_W-1:0]  wr_idx;
    logic [1:0]        wr_sel;
    logic              m_hit;
    logic [IDX_W-1:0]  m_idx;
    logic              pend;
    logic [IDX_W-1:0]  pend_idx;
    logic              cmp_in_ok;
    logic              cmp_out_ok;
    logic              cmp_setup;
    logic [LEN_W-1:0]  cmp_cnt;
    ep_st_t            m_st;
    ep_st_t            p_st;

    assign wr_idx = cpu_addr[IDX_W+1:2];
    assign wr_sel = cpu_addr[1:0];

    genvar g;
    generate
        for (g = 0; g < NUM_EP; g++) begin : g_ep
            usbep_slot u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_en      (cpu_we && (wr_idx == IDX_W'(g))),
                .wr_sel     (wr_sel),
                .wr_data    (cpu_wdata),
                .busy       (pend && (pend_idx == IDX_W'(g))),
                .cmp_in_ok  (cmp_in_ok  && (pend_idx == IDX_W'(g))),
                .cmp_out_ok (cmp_out_ok && (pend_idx == IDX_W'(g))),
                .cmp_setup  (cmp_setup  && (pend_idx == IDX_W'(g))),
                .cmp_cnt    (cmp_cnt),
                .st         (eps[g])
            );
        end
    endgenerate

    // CPU read multiplexer; write-one bit reads back as zero
    always_comb begin
        cpu_rdata = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (wr_idx == IDX_W'(i)) begin
                case (wr_sel)
                    SEL_SEG: cpu_rdata = {7'd0, eps[i].seg, 3'd0};
                    SEL_LEN: cpu_rdata = {7'd0, eps[i].len};
                    SEL_CFG: cpu_rdata = {8'd0, eps[i].dsq, eps[i].mode,
                                          eps[i].iso, eps[i].num};
                    default: cpu_rdata = {14'd0, eps[i].stall, 1'b0};
                endcase
            end
        end
    end

    usbep_match #(
        .NUM_EP (NUM_EP),
        .IDX_W  (IDX_W)
    ) u_match (
        .eps     (eps),
        .tok_pid (tok_pid),
        .tok_ep  (tok_ep),
        .hit     (m_hit),
        .idx     (m_idx)
    );

    // Select the matched and the pending endpoint's state
    always_comb begin
        m_st = '0;
        p_st = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (m_idx == IDX_W'(i))    m_st = eps[i];
            if (pend_idx == IDX_W'(i)) p_st = eps[i];
        end
    end

    usbep_resp #(
        .IDX_W     (IDX_W),
        .ADDR_W    (ADDR_W),
        .SRAM_BASE (SRAM_BASE)
    ) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .tok_valid  (tok_valid),
        .tok_pid    (tok_pid),
        .m_hit      (m_hit),
        .m_idx      (m_idx),
        .m_st       (m_st),
        .done_valid (done_valid),
        .done_ok    (done_ok),
        .done_cnt   (done_cnt),
        .p_st       (p_st),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_idx    (rsp_idx),
        .rsp_addr   (rsp_addr),
        .rsp_len    (rsp_len),
        .rsp_data1  (rsp_data1),
        .rsp_data   (rsp_data),
        .rsp_hs     (rsp_hs),
        .fin_valid  (fin_valid),
        .fin_hs     (fin_hs),
        .fin_err    (fin_err),
        .pend       (pend),
        .pend_idx   (pend_idx),
        .cmp_in_ok  (cmp_in_ok),
        .cmp_out_ok (cmp_out_ok),
        .cmp_setup  (cmp_setup),
        .cmp_cnt    (cmp_cnt)
    );

endmodule

// File: rtl/usbep_chk.sv
// Protocol checker for usb_ep_ctrl, attached by bind. Watches ports only.
module usbep_chk #(
    parameter int          IDX_W     = 2,
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] SRAM_BASE = 12'h100
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W+1:0]  cpu_addr,
    input logic [15:0]       cpu_rdata,
    input logic              tok_valid,
    input logic [1:0]        tok_pid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic              rsp_data,
    input logic [1:0]        rsp_hs,
    input logic              done_valid,
    input logic              fin_valid,
    input logic [1:0]        fin_hs,
    input logic              fin_err
);

    AST_RSP_FOLLOWS_TOK: assert property (@(posedge clk) disable iff (!rst_n) tok_valid |=> rsp_valid); // R12
    AST_RSP_NEEDS_TOK: assert property (@(posedge clk) disable iff (!rst_n) !tok_valid |=> !rsp_valid); // R12
    AST_FIN_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) fin_valid |-> $past(done_valid)); // R12
    AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_hit) |-> (rsp_hs == 2'd0 && !rsp_data)); // R3
    AST_NAK_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_hs == 2'd2) |-> !rsp_data); // R5
    AST_STALL_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_hs == 2'd3) |-> (!rsp_data && $past(tok_pid) != 2'd2)); // R6
    AST_SETUP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_hit && $past(tok_pid) == 2'd2) |-> (rsp_hs == 2'd1 && rsp_data)); // R11
    AST_OVERSIZE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n) fin_err |-> (fin_valid && fin_hs != 2'd1)); // R9
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> (rsp_addr[2:0] == SRAM_BASE[2:0])); // R2
    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (cpu_addr[1:0] == 2'd3) |-> !cpu_rdata[0]); // R10

endmodule

bind usb_ep_ctrl usbep_chk #(
    .IDX_W     (IDX_W),
    .ADDR_W    (ADDR_W),
    .SRAM_BASE (SRAM_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_rdata  (cpu_rdata),
    .tok_valid  (tok_valid),
    .tok_pid    (tok_pid),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_addr   (rsp_addr),
    .rsp_data   (rsp_data),
    .rsp_hs     (rsp_hs),
    .done_valid (done_valid),
    .fin_valid  (fin_valid),
    .fin_hs     (fin_hs),
    .fin_err    (fin_err)
);

// File: tb/sim_usb_ep_ctrl.sv
`timescale 1ns/1ps
module sim_usb_ep_ctrl;

    localparam int IDX_W = 2;
    localparam int NONE = 0, ACK = 1, NAK = 2, STALL = 3;
    localparam int P_OUT = 0, P_IN = 1, P_SETUP = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [3:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        tok_valid = 1'b0;
    logic [1:0]  tok_pid = '0;
    logic [3:0]  tok_ep = '0;
    logic        rsp_valid, rsp_hit, rsp_data1, rsp_data;
    logic [1:0]  rsp_idx, rsp_hs, fin_hs;
    logic [11:0] rsp_addr;
    logic [8:0]  rsp_len;
    logic        done_valid = 1'b0;
    logic        done_ok = 1'b0;
    logic [8:0]  done_cnt = '0;
    logic        fin_valid, fin_err;

    int checks = 0;
    int errors = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    usb_ep_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tok_valid(tok_valid),
        .tok_pid(tok_pid), .tok_ep(tok_ep), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_idx(rsp_idx), .rsp_addr(rsp_addr),
        .rsp_len(rsp_len), .rsp_data1(rsp_data1), .rsp_data(rsp_data),
        .rsp_hs(rsp_hs), .done_valid(done_valid), .done_ok(done_ok),
        .done_cnt(done_cnt), .fin_valid(fin_valid), .fin_hs(fin_hs),
        .fin_err(fin_err)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(int ep, int sel, int data);
        @(negedge clk);
        cpu_we    = 1'b1;
        cpu_addr  = 4'(ep * 4 + sel);
        cpu_wdata = 16'(data);
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic rd(string req, int ep, int sel, int exp);
        cpu_addr = 4'(ep * 4 + sel);
        #1;
        chk(req, "rdata", int'(cpu_rdata), exp);
    endtask

    // Drive a token; check the registered response 1 ns after the next edge
    task automatic tok(string req, int pid, int ep, int hit, int idx, int hs, int dat);
        @(negedge clk);
        tok_valid = 1'b1;
        tok_pid   = 2'(pid);
        tok_ep    = 4'(ep);
        @(posedge clk);
        #1;
        tok_valid = 1'b0;
        chk(req, "rsp_valid", int'(rsp_valid), 1);
        chk(req, "rsp_hit", int'(rsp_hit), hit);
        if (hit != 0) chk(req, "rsp_idx", int'(rsp_idx), idx);
        chk(req, "rsp_hs", int'(rsp_hs), hs);
        chk(req, "rsp_data", int'(rsp_data), dat);
    endtask

    task automatic done(string req, int ok, int cnt, int hs, int err);
        @(negedge clk);
        done_valid = 1'b1;
        done_ok    = ok[0];
        done_cnt   = 9'(cnt);
        @(posedge clk);
        #1;
        done_valid = 1'b0;
        chk(req, "fin_valid", int'(fin_valid), 1);
        chk(req, "fin_hs", int'(fin_hs), hs);
        chk(req, "fin_err", int'(fin_err), err);
    endtask

    task automatic t_reset();
        chk("R1", "rsp_valid", int'(rsp_valid), 0);
        chk("R1", "fin_valid", int'(fin_valid), 0);
        rd("R1", 0, 2, 0);
        rd("R1", 1, 1, 0);
        rd("R1", 3, 0, 0);
    endtask

    task automatic t_in_path();
        wr(0, 2, 'h41);                 // ep0: IN, number 1
        wr(0, 0, 5 << 3);               // segment 5
        rd("R2", 0, 0, 'h28);
        tok("R5", P_IN, 1, 1, 0, NAK, 0);
        chk("R2", "rsp_addr", int'(rsp_addr), 'h128);
        wr(0, 1, 64);
        tok("R5", P_IN, 1, 1, 0, NONE, 1);
        chk("R5", "rsp_len", int'(rsp_len), 64);
        chk("R8", "rsp_data1", int'(rsp_data1), 0);
        done("R8", 0, 0, NONE, 0);      // failed: nothing changes
        tok("R8", P_IN, 1, 1, 0, NONE, 1);
        chk("R8", "rsp_data1", int'(rsp_data1), 0);
        done("R8", 1, 0, NONE, 0);
        rd("R8", 0, 2, 'hC1);
        tok("R8", P_IN, 1, 1, 0, NAK, 0);
        wr(0, 1, 3);
        tok("R8", P_IN, 1, 1, 0, NONE, 1);
        chk("R8", "rsp_data1", int'(rsp_data1), 1);
        done("R8", 1, 0, NONE, 0);
    endtask

    task automatic t_disabled();
        wr(1, 2, 'h62);                 // mode 11, number 2
        tok("R3", P_IN, 2, 0, 0, NONE, 0);
        tok("R3", P_OUT, 2, 0, 0, NONE, 0);
        wr(1, 2, 'h02);                 // mode 00
        tok("R3", P_IN, 2, 0, 0, NONE, 0);
    endtask

    task automatic t_match();
        wr(2, 2, 'h23);                 // ep2 OUT number 3
        wr(3, 2, 'h23);                 // ep3 OUT number 3
        tok("R4", P_OUT, 3, 1, 2, NAK, 0);
        tok("R4", P_IN, 3, 0, 0, NONE, 0);
    endtask

    task automatic t_out();
        wr(2, 0, 2 << 3);
        wr(2, 1, 16);
        tok("R5", P_OUT, 3, 1, 2, ACK, 1);
        chk("R5", "rsp_len", int'(rsp_len), 16);
        chk("R2", "rsp_addr", int'(rsp_addr), 'h110);
        done("R9", 1, 10, ACK, 0);
        rd("R9", 2, 1, 10);
        tok("R9", P_OUT, 3, 1, 2, NAK, 0);
        wr(2, 1, 8);
        tok("R9", P_OUT, 3, 1, 2, ACK, 1);
        done("R9", 1, 20, NONE, 1);
        tok("R9", P_OUT, 3, 1, 2, ACK, 1);
        done("R9", 1, 4, ACK, 0);
        rd("R9", 2, 1, 4);
    endtask

    task automatic t_stall_setup();
        wr(2, 3, 2);
        rd("R6", 2, 3, 2);
        tok("R6", P_OUT, 3, 1, 2, STALL, 0);
        wr(2, 1, 8);
        tok("R6", P_OUT, 3, 1, 2, STALL, 0);
        tok("R11", P_SETUP, 3, 1, 2, ACK, 1);
        chk("R11", "rsp_data1", int'(rsp_data1), 0);
        done("R11", 1, 8, ACK, 0);
        rd("R11", 2, 1, 8);
        rd("R11", 2, 2, 'hA3);
        wr(2, 3, 0);
    endtask

    task automatic t_iso();
        wr(3, 2, 'h34);                 // ep3 iso OUT number 4
        tok("R7", P_OUT, 4, 1, 3, NONE, 0);
        wr(3, 1, 32);
        tok("R7", P_OUT, 4, 1, 3, NONE, 1);
        done("R7", 1, 5, NONE, 0);
        rd("R7", 3, 1, 5);
    endtask

    task automatic t_clear_ready();
        wr(0, 1, 10);
        wr(0, 3, 1);
        rd("R10", 0, 3, 0);
        tok("R10", P_IN, 1, 1, 0, NAK, 0);
        wr(0, 1, 10);
        tok("R10", P_IN, 1, 1, 0, NONE, 1);
        wr(0, 3, 1);                    // busy: must not disarm
        done("R10", 0, 0, NONE, 0);
        tok("R10", P_IN, 1, 1, 0, NONE, 1);
        done("R10", 1, 0, NONE, 0);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_in_path();
        t_disabled();
        t_match();
        t_out();
        t_stall_setup();
        t_iso();
        t_clear_ready();
        repeat (2) @(posedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

endmodule